// File: doc/BRIEF.md
# Reorder Buffer with Destination Renaming

This block keeps the program order of instructions in a pipeline that dispatches in order but feeds functional units of unequal latency. Each dispatched instruction claims the slot at the tail of a circular buffer. Its destination register is renamed to that slot's index, which becomes the tag the functional unit carries with the instruction. Results come back in any order, together with that tag and a fault flag, and are stored in their slots.

Slots leave from the head strictly in program order, and each one writes its result into the architectural register file as it leaves. A slot whose fault flag is set discards the whole buffer when it reaches the head and raises a one-cycle exception strobe. That slot writes nothing, and neither does any younger instruction, so the exception is precise.

Operand lookup ports give the decode stage each source register. A per-register table holds the newest slot that will write that register. If such a slot exists, the port returns its result when it has one, or the tag to wait for when it does not. Otherwise the port returns the register file's value.

Top module: `rename_rob`

## Requirements
- R1: After reset the buffer is empty: `allocReady` is 1, `allocTag` is 0, `retValid` and `excPulse` are 0, and every lookup reports not pending, ready, with data 0.
- R2: Accepted allocations receive tags 0, 1, 2, … in order, wrapping modulo DEPTH. `allocReady` is 0 whenever DEPTH slots are occupied, and an allocation request made while `allocReady` is 0 is ignored.
- R3: A lookup of a register whose newest writer has not reported a result gives `rdPending`=1, `rdReady`=0 and that writer's slot index on `rdTag`.
- R4: Once that writer's result has been written back, the lookup gives `rdReady`=1 and the result on `rdData`, before the writer retires.
- R5: When several live slots target the same register, the lookup reports the youngest of them.
- R6: Retirement is strictly in order. A finished slot never retires while an older slot is unfinished. When the head slot is finished without a fault, `retValid` is 1 in that cycle, with its destination on `retDest` and its result on `retData`.
- R7: A retiring slot writes its result into the register file. A register stays pending until its newest writer retires, and afterwards a lookup returns the register file value with `rdPending`=0.
- R8: When a finished slot with its fault flag set is at the head, `excPulse` is 1 for that cycle and `retValid` is 0. All slots are discarded, no register file entry changes, every register reads as not pending, and the next tag is 0.
- R9: An allocation and a retirement in the same cycle leave the occupancy unchanged.
- R10: A writeback to a slot that holds no live instruction is ignored: a later instruction that takes that slot reads as unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Dispatch requests a slot this cycle |
| allocDest | input | REG_W | Destination register of the dispatched instruction |
| allocReady | output | 1 | A slot is free and no flush is in progress |
| allocTag | output | IDX_W | Slot index given to the dispatched instruction |
| wbValid | input | 1 | A functional unit returns a result |
| wbTag | input | IDX_W | Slot the result belongs to |
| wbData | input | DATA_W | Result value |
| wbExc | input | 1 | The instruction faulted |
| rdReg | input | NRD*REG_W | Source registers to look up, one field per port |
| rdReady | output | NRD | Value is available on `rdData` |
| rdPending | output | NRD | An unretired slot is the newest writer |
| rdTag | output | NRD*IDX_W | Slot index of that writer |
| rdData | output | NRD*DATA_W | Operand value |
| retValid | output | 1 | Head slot retires this cycle |
| retDest | output | REG_W | Register written by the retiring slot |
| retData | output | DATA_W | Value written by the retiring slot |
| excPulse | output | 1 | Head slot faulted; buffer discarded this cycle |

## Verification
The bench builds the block with DEPTH 8, 16 registers, 32-bit data and two lookup ports. Destinations are drawn from only eight registers, so several live slots often share a target and the youngest-writer and stale-retire paths come up often. With eight slots, a burst of dispatches can fill the buffer, and the tags wrap many times in a few thousand cycles. The random phase returns results out of order and makes roughly one in sixteen faulting, so flushes happen with the buffer at many different fill levels.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Per-cycle commands from the control unit to the storage.
  typedef struct packed {
    logic allocEn;   // write a new slot at the tail
    logic retireEn;  // commit the head slot to the register file
    logic flushEn;   // discard all slots (faulting head)
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocValid,
  input  logic             headValid,
  input  logic             headDone,
  input  logic             headExc,
  output robStrobe_t       strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic             allocReady
);
  logic [CNT_W-1:0] count;
  logic             headFinished;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headFinished    = headValid && headDone;
  assign strobe.flushEn  = headFinished && headExc;
  assign strobe.retireEn = headFinished && !headExc;
  assign allocReady      = (count != CNT_W'(DEPTH)) && !strobe.flushEn;
  assign strobe.allocEn  = allocValid && allocReady;

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.flushEn) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
    end else begin
      if (strobe.retireEn) headIdx <= stepIdx(headIdx);
      if (strobe.allocEn)  tailIdx <= stepIdx(tailIdx);
      case ({strobe.allocEn, strobe.retireEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NREGS  = 16,
  parameter int DATA_W = 32,
  parameter int NRD    = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int REG_W = $clog2(NREGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  robStrobe_t            strobe,
  input  logic [IDX_W-1:0]      headIdx,
  input  logic [IDX_W-1:0]      tailIdx,
  input  logic [REG_W-1:0]      allocDest,
  input  logic                  wbValid,
  input  logic [IDX_W-1:0]      wbTag,
  input  logic [DATA_W-1:0]     wbData,
  input  logic                  wbExc,
  input  logic [NRD*REG_W-1:0]  rdReg,
  output logic                  headValid,
  output logic                  headDone,
  output logic                  headExc,
  output logic [REG_W-1:0]      retDest,
  output logic [DATA_W-1:0]     retData,
  output logic [NRD-1:0]        rdReady,
  output logic [NRD-1:0]        rdPending,
  output logic [NRD*IDX_W-1:0]  rdTag,
  output logic [NRD*DATA_W-1:0] rdData
);
  // slot storage
  logic              slotLive [DEPTH];
  logic              slotDone [DEPTH];
  logic              slotFault[DEPTH];
  logic [REG_W-1:0]  slotDest [DEPTH];
  logic [DATA_W-1:0] slotValue[DEPTH];
  // rename table and architectural registers
  logic              mapBusy [NREGS];
  logic [IDX_W-1:0]  mapSlot [NREGS];
  logic [DATA_W-1:0] archReg [NREGS];

  assign headValid = slotLive[headIdx];
  assign headDone  = slotDone[headIdx];
  assign headExc   = slotFault[headIdx];
  assign retDest   = slotDest[headIdx];
  assign retData   = slotValue[headIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) begin
        slotLive[s]  <= 1'b0;
        slotDone[s]  <= 1'b0;
        slotFault[s] <= 1'b0;
        slotDest[s]  <= '0;
        slotValue[s] <= '0;
      end
    end else if (strobe.flushEn) begin
      for (int s = 0; s < DEPTH; s++) slotLive[s] <= 1'b0;
    end else begin
      if (wbValid && slotLive[wbTag]) begin
        slotDone[wbTag]  <= 1'b1;
        slotFault[wbTag] <= wbExc;
        slotValue[wbTag] <= wbData;
      end
      if (strobe.retireEn) slotLive[headIdx] <= 1'b0;
      if (strobe.allocEn) begin
        slotLive[tailIdx]  <= 1'b1;
        slotDone[tailIdx]  <= 1'b0;
        slotFault[tailIdx] <= 1'b0;
        slotDest[tailIdx]  <= allocDest;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) begin
        mapBusy[r] <= 1'b0;
        mapSlot[r] <= '0;
        archReg[r] <= '0;
      end
    end else if (strobe.flushEn) begin
      for (int r = 0; r < NREGS; r++) mapBusy[r] <= 1'b0;
    end else begin
      if (strobe.retireEn) begin
        archReg[retDest] <= retData;
        // a newer writer keeps the register pending
        if (mapSlot[retDest] == headIdx) mapBusy[retDest] <= 1'b0;
      end
      if (strobe.allocEn) begin
        mapBusy[allocDest] <= 1'b1;
        mapSlot[allocDest] <= tailIdx;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_lookup
    logic [REG_W-1:0] srcReg;
    logic [IDX_W-1:0] srcSlot;
    assign srcReg     = rdReg[p*REG_W +: REG_W];
    assign srcSlot    = mapSlot[srcReg];
    assign rdPending[p] = mapBusy[srcReg];
    assign rdReady[p]   = !mapBusy[srcReg] || slotDone[srcSlot];
    assign rdTag[p*IDX_W +: IDX_W]   = srcSlot;
    assign rdData[p*DATA_W +: DATA_W] = mapBusy[srcReg] ? slotValue[srcSlot] : archReg[srcReg];
  end
endmodule

// File: rtl/rename_rob.sv
module rename_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NREGS  = 16,
  parameter int DATA_W = 32,
  parameter int NRD    = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int REG_W = $clog2(NREGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  allocValid,
  input  logic [REG_W-1:0]      allocDest,
  output logic                  allocReady,
  output logic [IDX_W-1:0]      allocTag,
  input  logic                  wbValid,
  input  logic [IDX_W-1:0]      wbTag,
  input  logic [DATA_W-1:0]     wbData,
  input  logic                  wbExc,
  input  logic [NRD*REG_W-1:0]  rdReg,
  output logic [NRD-1:0]        rdReady,
  output logic [NRD-1:0]        rdPending,
  output logic [NRD*IDX_W-1:0]  rdTag,
  output logic [NRD*DATA_W-1:0] rdData,
  output logic                  retValid,
  output logic [REG_W-1:0]      retDest,
  output logic [DATA_W-1:0]     retData,
  output logic                  excPulse
);
  robStrobe_t       strobe;
  logic [IDX_W-1:0] headIdx;
  logic             headValid, headDone, headExc;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .allocValid(allocValid),
    .headValid(headValid), .headDone(headDone), .headExc(headExc),
    .strobe(strobe), .headIdx(headIdx), .tailIdx(allocTag), .allocReady(allocReady)
  );

  rob_data #(.DEPTH(DEPTH), .NREGS(NREGS), .DATA_W(DATA_W), .NRD(NRD)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .headIdx(headIdx), .tailIdx(allocTag),
    .allocDest(allocDest), .wbValid(wbValid), .wbTag(wbTag), .wbData(wbData), .wbExc(wbExc),
    .rdReg(rdReg), .headValid(headValid), .headDone(headDone), .headExc(headExc),
    .retDest(retDest), .retData(retData),
    .rdReady(rdReady), .rdPending(rdPending), .rdTag(rdTag), .rdData(rdData)
  );

  assign retValid = strobe.retireEn;
  assign excPulse = strobe.flushEn;
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH  = 8,
  parameter int NREGS  = 16,
  parameter int DATA_W = 32,
  parameter int NRD    = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int REG_W = $clog2(NREGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             allocValid,
  input logic             allocReady,
  input logic [IDX_W-1:0] allocTag,
  input logic             retValid,
  input logic             excPulse
);
  int occ;

  always_ff @(posedge clk) begin
    if (!rst_n || excPulse) occ <= 0;
    else occ <= occ + ((allocValid && allocReady) ? 1 : 0) - (retValid ? 1 : 0);
  end

  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == DEPTH) |-> !allocReady);

  a_r2_tag_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (allocValid && allocReady) |=> (allocTag == IDX_W'(($past(allocTag) + 1) % DEPTH)));

  a_r6_retire_excludes_fault: assert property (@(posedge clk) disable iff (!rst_n)
    retValid |-> !excPulse);

  a_r1_empty_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 0) |-> (!retValid && !excPulse));

  a_r8_flush_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    excPulse |=> (allocTag == '0 && !retValid && !excPulse));
endmodule

bind rename_rob rob_checker #(.DEPTH(DEPTH), .NREGS(NREGS), .DATA_W(DATA_W), .NRD(NRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .allocValid(allocValid), .allocReady(allocReady),
  .allocTag(allocTag), .retValid(retValid), .excPulse(excPulse)
);

// File: tb/rename_rob_bench.sv
module rename_rob_bench;
  localparam int DEPTH = 8, NREGS = 16, DATA_W = 32, NRD = 2;
  localparam int IDX_W = $clog2(DEPTH), REG_W = $clog2(NREGS);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                  rst_n;
  logic                  allocValid, allocReady;
  logic [REG_W-1:0]      allocDest;
  logic [IDX_W-1:0]      allocTag;
  logic                  wbValid, wbExc;
  logic [IDX_W-1:0]      wbTag;
  logic [DATA_W-1:0]     wbData;
  logic [NRD*REG_W-1:0]  rdReg;
  logic [NRD-1:0]        rdReady, rdPending;
  logic [NRD*IDX_W-1:0]  rdTag;
  logic [NRD*DATA_W-1:0] rdData;
  logic                  retValid, excPulse;
  logic [REG_W-1:0]      retDest;
  logic [DATA_W-1:0]     retData;

  rename_rob #(.DEPTH(DEPTH), .NREGS(NREGS), .DATA_W(DATA_W), .NRD(NRD)) u_rename_rob (
    .clk(clk), .rst_n(rst_n), .allocValid(allocValid), .allocDest(allocDest),
    .allocReady(allocReady), .allocTag(allocTag), .wbValid(wbValid), .wbTag(wbTag),
    .wbData(wbData), .wbExc(wbExc), .rdReg(rdReg), .rdReady(rdReady), .rdPending(rdPending),
    .rdTag(rdTag), .rdData(rdData), .retValid(retValid), .retDest(retDest),
    .retData(retData), .excPulse(excPulse)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // expected-state model built from the requirements
  bit              mV[DEPTH], mD[DEPTH], mE[DEPTH];
  int              mDst[DEPTH];
  logic [DATA_W-1:0] mVal[DEPTH];
  int              mHead = 0, mTail = 0, mCnt = 0;
  bit              pend[NREGS];
  int              ptag[NREGS];
  logic [DATA_W-1:0] arch[NREGS];
  int              rdSel[NRD];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] dataOf(int p);
    return rdData[p*DATA_W +: DATA_W];
  endfunction
  function automatic int tagOf(int p);
    return int'(rdTag[p*IDX_W +: IDX_W]);
  endfunction

  task automatic checkRead(int p);
    int r = rdSel[p];
    if (pend[r]) begin
      chk(rdPending[p] == 1'b1, "R3", "rdPending", rdPending[p], 1);
      chk(tagOf(p) == ptag[r], "R5", "rdTag youngest", tagOf(p), ptag[r]);
      chk(rdReady[p] == mD[ptag[r]], "R3", "rdReady", rdReady[p], mD[ptag[r]]);
      if (mD[ptag[r]]) chk(dataOf(p) == mVal[ptag[r]], "R4", "rdData early", dataOf(p), mVal[ptag[r]]);
    end else begin
      chk(rdPending[p] == 1'b0, "R7", "rdPending", rdPending[p], 0);
      chk(rdReady[p] == 1'b1, "R7", "rdReady", rdReady[p], 1);
      chk(dataOf(p) == arch[r], "R7", "rdData regfile", dataOf(p), arch[r]);
    end
  endtask

  task automatic step(bit aV, int aDst, bit wV, int wT, logic [DATA_W-1:0] wD, bit wX);
    bit eFlush, eRet, eReady, wHit;
    @(negedge clk);
    allocValid = aV; allocDest = REG_W'(aDst);
    wbValid = wV; wbTag = IDX_W'(wT); wbData = wD; wbExc = wX;
    for (int p = 0; p < NRD; p++) rdReg[p*REG_W +: REG_W] = REG_W'(rdSel[p]);
    #1;
    eFlush = mV[mHead] && mD[mHead] && mE[mHead];
    eRet   = mV[mHead] && mD[mHead] && !mE[mHead];
    eReady = (mCnt < DEPTH) && !eFlush;
    chk(allocReady == eReady, "R2", "allocReady", allocReady, eReady);
    chk(int'(allocTag) == mTail, "R2", "allocTag", allocTag, mTail);
    chk(excPulse == eFlush, "R8", "excPulse", excPulse, eFlush);
    chk(retValid == eRet, "R6", "retValid", retValid, eRet);
    if (eRet) begin
      chk(int'(retDest) == mDst[mHead], "R6", "retDest", retDest, mDst[mHead]);
      chk(retData == mVal[mHead], "R7", "retData", retData, mVal[mHead]);
    end
    for (int p = 0; p < NRD; p++) checkRead(p);
    // advance the model to the next edge
    if (eFlush) begin
      for (int s = 0; s < DEPTH; s++) mV[s] = 0;
      for (int r = 0; r < NREGS; r++) pend[r] = 0;
      mHead = 0; mTail = 0; mCnt = 0;
    end else begin
      wHit = wV && mV[wT];
      if (wHit) begin mD[wT] = 1; mE[wT] = wX; mVal[wT] = wD; end
      if (eRet) begin
        arch[mDst[mHead]] = mVal[mHead];
        if (ptag[mDst[mHead]] == mHead) pend[mDst[mHead]] = 0;
        mV[mHead] = 0; mHead = (mHead + 1) % DEPTH; mCnt--;
      end
      if (aV && eReady) begin
        mV[mTail] = 1; mD[mTail] = 0; mE[mTail] = 0; mDst[mTail] = aDst;
        pend[aDst] = 1; ptag[aDst] = mTail;
        mTail = (mTail + 1) % DEPTH; mCnt++;
      end
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, '0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1ead_5eed));
    for (int r = 0; r < NREGS; r++) begin pend[r] = 0; ptag[r] = 0; arch[r] = '0; end
    for (int s = 0; s < DEPTH; s++) begin mV[s] = 0; mD[s] = 0; mE[s] = 0; mDst[s] = 0; mVal[s] = '0; end
    rst_n = 0; allocValid = 0; allocDest = '0; wbValid = 0; wbTag = '0; wbData = '0; wbExc = 0; rdReg = '0;
    rdSel[0] = 3; rdSel[1] = 5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(allocReady == 1'b1, "R1", "allocReady", allocReady, 1);
    chk(allocTag == '0, "R1", "allocTag", allocTag, 0);
    chk(!retValid && !excPulse, "R1", "retire/exc", {retValid, excPulse}, 0);
    chk(rdPending == '0 && rdReady == '1, "R1", "lookup flags", {rdPending, rdReady}, 2'b11);
    chk(rdData == '0, "R1", "lookup data", rdData, 0);

    // two writers of r3, one of r5; younger finishes first
    step(1, 3, 0, 0, '0, 0);
    step(1, 3, 0, 0, '0, 0);
    step(1, 5, 0, 0, '0, 0);
    step(0, 0, 1, 1, 32'h1111, 0);
    idle();
    chk(tagOf(0) == 1, "R5", "youngest tag r3", tagOf(0), 1);
    chk(rdReady[0] && dataOf(0) == 32'h1111, "R4", "early value r3", dataOf(0), 32'h1111);
    chk(retValid == 1'b0, "R6", "no retire past unfinished head", retValid, 0);
    step(0, 0, 1, 0, 32'h2222, 0);
    idle();
    chk(retValid && retData == 32'h2222, "R6", "head retires", retData, 32'h2222);
    idle();
    chk(rdPending[0] == 1'b1, "R7", "r3 still pending after stale retire", rdPending[0], 1);
    idle();
    chk(!rdPending[0] && dataOf(0) == 32'h1111, "R7", "r3 from regfile", dataOf(0), 32'h1111);

    // R10: writeback to an empty slot is dropped
    step(0, 0, 1, 6, 32'hdead, 0);
    rdSel[1] = 7;
    for (int k = 0; k < 4; k++) step(1, 7, 0, 0, '0, 0);
    idle();
    chk(rdPending[1] && tagOf(1) == 6 && !rdReady[1], "R10", "slot 6 unfinished", rdReady[1], 0);

    // fill to capacity
    for (int k = 0; k < 3; k++) step(1, 8, 0, 0, '0, 0);
    idle();
    chk(allocReady == 1'b0, "R2", "full blocks", allocReady, 0);
    rdSel[0] = 9;
    step(1, 9, 0, 0, '0, 0);
    idle();
    chk(rdPending[0] == 1'b0, "R2", "ignored alloc leaves r9 idle", rdPending[0], 0);

    // R9: alloc and retire in the same cycle
    step(0, 0, 1, 2, 32'h3333, 0);
    step(0, 0, 1, 3, 32'h4444, 0);
    step(1, 10, 0, 0, '0, 0);
    step(1, 11, 0, 0, '0, 0);
    idle();
    chk(allocReady == 1'b0, "R9", "occupancy held then full", allocReady, 0);

    // R8: faulting slot flushes, older write kept
    rdSel[0] = 7;
    step(0, 0, 1, 5, 32'hbad0, 1);
    step(0, 0, 1, 4, 32'h0044, 0);
    repeat (4) idle();
    chk(!rdPending[0] && dataOf(0) == 32'h0044, "R8", "r7 precise value", dataOf(0), 32'h0044);
    chk(allocTag == '0 && allocReady, "R8", "restart at tag 0", allocTag, 0);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit aV, wV, wX;
      int wT, start;
      aV = ($urandom_range(0, 9) < 6);
      wV = 0; wT = 0;
      if ($urandom_range(0, 1) == 1) begin
        start = $urandom_range(0, DEPTH - 1);
        for (int k = 0; k < DEPTH; k++) begin
          int s = (start + k) % DEPTH;
          if (!wV && mV[s] && !mD[s]) begin wV = 1; wT = s; end
        end
      end
      wX = ($urandom_range(0, 15) == 0);
      for (int p = 0; p < NRD; p++) rdSel[p] = $urandom_range(0, 7);
      step(aV, $urandom_range(0, 7), wV, wT, $urandom, wX);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule